// File: doc/BRIEF.md
# Encoder Period Averaging and Rate Unit

This block turns a stream of encoder tick strobes into a speed estimate. A free-running cycle counter measures how many clock cycles pass between consecutive ticks. The most recent periods are kept in a sliding window whose length is a power of two, so their mean is a sum followed by a shift. When the window holds enough fresh periods and their mean stays within a configured ceiling, a restoring divider computes distance-per-count divided by the mean period. The quotient is signed by the direction of the tick that launched the division, and a one-cycle strobe marks each new result.

Window length, period ceiling and distance-per-count are captured by an initialization pulse. A shaft that goes quiet is flagged as stopped as soon as the running counter passes the ceiling, without waiting for another tick. Every stop and every initialization empties the window, so a rate is only reported again after a full window of new periods.

Top module: `enc_rate_unit`

## Requirements
- R1: Out of reset `stopped_o` is 1, `avg_period_o` is 0, `rate_o` is 0 and `rate_valid_o` is 0.
- R2: A period is the number of clock cycles between the edges that sample two consecutive ticks. The first tick after reset, initialization or a stop only starts timing and produces no period.
- R3: With a window of 2^k periods (k taken from `win_log2_i`, values above 4 treated as 4), `avg_period_o` equals floor(sum of the last 2^k periods / 2^k). It is updated on the clock edge that samples the completing tick.
- R4: After initialization or a stop, `avg_period_o` is not updated and `stopped_o` stays 1 until 2^k fresh periods have been collected.
- R5: While `stopped_o` is 1, `rate_o` is 0. An average above the configured maximum sets `stopped_o`, and a reported average never exceeds that maximum while `stopped_o` is 0.
- R6: If no tick arrives and the cycles since the last tick exceed the maximum period, `stopped_o` rises on the following edge. The rate is zeroed and the window is emptied.
- R7: A new rate equals floor(distance_per_count / average). `rate_valid_o` is high for exactly one cycle, DPC_W+1 cycles after the edge that sampled the launching tick.
- R8: The rate is positive when `dir_i` was 1 on the launching tick and negative when it was 0.
- R9: Configuration inputs take effect only on `init_i`. Changing them without `init_i` leaves results unchanged.
- R10: A new qualifying tick during a division restarts it. Only the latest result is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Capture configuration and empty the window |
| win_log2_i | input | $clog2(WIN_LOG2_MAX+1) | Log2 of the averaging window |
| max_period_i | input | CNT_W | Period ceiling in cycles |
| dist_per_cnt_i | input | DPC_W | Distance per count, the dividend |
| tick_i | input | 1 | Encoder tick strobe |
| dir_i | input | 1 | Direction of the tick, 1 is forward |
| avg_period_o | output | CNT_W | Averaged period in cycles |
| stopped_o | output | 1 | Shaft considered stopped |
| rate_o | output | DPC_W+1 | Signed rate |
| rate_valid_o | output | 1 | One-cycle strobe for a new rate |

## Verification
The bench builds the unit with 16-bit period and distance fields and the full 16-entry window. This keeps division latency at 17 cycles and lets every window size, including the clamped value, run within a few hundred cycles. Small ceilings make the timeout edge reachable to the exact cycle. Short tick spacing makes a division restart observable.

// File: rtl/enc_rate_pkg.sv
`timescale 1ns/1ps
package enc_rate_pkg;
  typedef enum logic {
    DIV_IDLE = 1'b0,
    DIV_BUSY = 1'b1
  } div_state_e;
endpackage

// File: rtl/enc_period_timer.sv
`timescale 1ns/1ps
module enc_period_timer #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] max_period_i,
  output logic             armed_o,
  output logic             timeout_o,
  output logic [CNT_W-1:0] period_o
);
  logic [CNT_W-1:0] timer_q;
  logic             armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timer_q <= '0;
    end else if (tick_i) begin
      timer_q <= CNT_W'(1);
    end else if (timer_q != '1) begin
      timer_q <= timer_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
    end else if (clear_i) begin
      armed_q <= 1'b0;
    end else if (tick_i) begin
      armed_q <= 1'b1;
    end else if (timeout_o) begin
      armed_q <= 1'b0;
    end
  end

  assign timeout_o = armed_q && (timer_q > max_period_i);
  assign armed_o   = armed_q;
  assign period_o  = timer_q;
endmodule

// File: rtl/enc_avg_window.sv
`timescale 1ns/1ps
module enc_avg_window #(
  parameter int unsigned CNT_W    = 24,
  parameter int unsigned LOG2_MAX = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              clear_i,
  input  logic                              push_i,
  input  logic [CNT_W-1:0]                  sample_i,
  input  logic [$clog2(LOG2_MAX+1)-1:0]     win_log2_i,
  output logic [CNT_W-1:0]                  avg_next_o,
  output logic                              full_next_o
);
  localparam int unsigned DEPTH  = 1 << LOG2_MAX;
  localparam int unsigned SUM_W  = CNT_W + LOG2_MAX;
  localparam int unsigned FILL_W = LOG2_MAX + 1;

  logic [CNT_W-1:0]    hist_q [DEPTH];
  logic [SUM_W-1:0]    sum_q;
  logic [FILL_W-1:0]   fill_q;
  logic [FILL_W-1:0]   win_n;
  logic [LOG2_MAX-1:0] evict_idx;
  logic [CNT_W-1:0]    evict;
  logic [SUM_W-1:0]    sum_next;

  assign win_n     = FILL_W'(1) << win_log2_i;
  assign evict_idx = LOG2_MAX'(win_n - FILL_W'(1));
  // entries past the window are zero after a clear, so evicting them is harmless
  assign evict     = hist_q[evict_idx];
  assign sum_next  = sum_q + SUM_W'(sample_i) - SUM_W'(evict);
  assign avg_next_o  = CNT_W'(sum_next >> win_log2_i);
  assign full_next_o = ({1'b0, fill_q} + (FILL_W+1)'(1)) >= {1'b0, win_n};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q[0] <= '0;
    end else if (clear_i) begin
      hist_q[0] <= '0;
    end else if (push_i) begin
      hist_q[0] <= sample_i;
    end
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_hist
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hist_q[g] <= '0;
      end else if (clear_i) begin
        hist_q[g] <= '0;
      end else if (push_i) begin
        hist_q[g] <= hist_q[g-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q  <= '0;
      fill_q <= '0;
    end else if (clear_i) begin
      sum_q  <= '0;
      fill_q <= '0;
    end else if (push_i) begin
      sum_q <= sum_next;
      if (fill_q < win_n) fill_q <= fill_q + FILL_W'(1);
    end
  end
endmodule

// File: rtl/enc_seq_divider.sv
`timescale 1ns/1ps
module enc_seq_divider
  import enc_rate_pkg::*;
#(
  parameter int unsigned NUM_W = 24,
  parameter int unsigned DEN_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             abort_i,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic [NUM_W-1:0] quo_o,
  output logic             done_o
);
  localparam int unsigned STEP_W = $clog2(NUM_W + 1);

  div_state_e       state_q;
  logic [STEP_W-1:0] step_q;
  logic [NUM_W-1:0] quo_q;
  logic [DEN_W:0]   rem_q;
  logic [DEN_W-1:0] den_q;
  logic             done_q;
  logic [DEN_W:0]   rem_sh;
  logic [DEN_W+1:0] diff;
  logic             fits;

  assign rem_sh = {rem_q[DEN_W-1:0], quo_q[NUM_W-1]};
  assign diff   = {1'b0, rem_sh} - {2'b00, den_q};
  assign fits   = !diff[DEN_W+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DIV_IDLE;
      step_q  <= '0;
      quo_q   <= '0;
      rem_q   <= '0;
      den_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        state_q <= DIV_IDLE;
      end else if (start_i) begin
        state_q <= DIV_BUSY;
        step_q  <= STEP_W'(NUM_W);
        quo_q   <= num_i;
        rem_q   <= '0;
        den_q   <= den_i;
      end else if (state_q == DIV_BUSY) begin
        rem_q  <= fits ? diff[DEN_W:0] : rem_sh;
        quo_q  <= {quo_q[NUM_W-2:0], fits};
        step_q <= step_q - STEP_W'(1);
        if (step_q == STEP_W'(1)) begin
          state_q <= DIV_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

  assign quo_o  = quo_q;
  assign done_o = done_q;
endmodule

// File: rtl/enc_rate_unit.sv
`timescale 1ns/1ps
module enc_rate_unit #(
  parameter int unsigned CNT_W        = 24,
  parameter int unsigned DPC_W        = 24,
  parameter int unsigned WIN_LOG2_MAX = 4
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                init_i,
  input  logic [$clog2(WIN_LOG2_MAX+1)-1:0]   win_log2_i,
  input  logic [CNT_W-1:0]                    max_period_i,
  input  logic [DPC_W-1:0]                    dist_per_cnt_i,
  input  logic                                tick_i,
  input  logic                                dir_i,
  output logic [CNT_W-1:0]                    avg_period_o,
  output logic                                stopped_o,
  output logic signed [DPC_W:0]               rate_o,
  output logic                                rate_valid_o
);
  localparam int unsigned K_W = $clog2(WIN_LOG2_MAX + 1);

  logic [K_W-1:0]   win_q;
  logic [CNT_W-1:0] max_q;
  logic [DPC_W-1:0] dpc_q;
  logic             sign_q;
  logic [CNT_W-1:0] avg_q;
  logic             stopped_q;
  logic signed [DPC_W:0] rate_q;
  logic             valid_q;

  logic             armed;
  logic             timeout;
  logic [CNT_W-1:0] period;
  logic             push;
  logic [CNT_W-1:0] avg_next;
  logic             full_next;
  logic             over_max;
  logic             accept;
  logic             win_clear;
  logic             div_abort;
  logic [DPC_W-1:0] quo;
  logic             div_done;
  logic [K_W-1:0]   win_clamped;

  assign win_clamped = (win_log2_i > K_W'(WIN_LOG2_MAX)) ? K_W'(WIN_LOG2_MAX) : win_log2_i;

  enc_period_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (init_i),
    .tick_i       (tick_i),
    .max_period_i (max_q),
    .armed_o      (armed),
    .timeout_o    (timeout),
    .period_o     (period)
  );

  assign push      = tick_i && armed && !timeout && !init_i;
  assign over_max  = avg_next > max_q;
  assign accept    = push && full_next && !over_max;
  assign win_clear = init_i || timeout || (push && full_next && over_max);
  assign div_abort = win_clear;

  enc_avg_window #(.CNT_W(CNT_W), .LOG2_MAX(WIN_LOG2_MAX)) u_window (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (win_clear),
    .push_i      (push),
    .sample_i    (period),
    .win_log2_i  (win_q),
    .avg_next_o  (avg_next),
    .full_next_o (full_next)
  );

  enc_seq_divider #(.NUM_W(DPC_W), .DEN_W(CNT_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .abort_i (div_abort),
    .start_i (accept),
    .num_i   (dpc_q),
    .den_i   (avg_next),
    .quo_o   (quo),
    .done_o  (div_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q     <= '0;
      max_q     <= '0;
      dpc_q     <= '0;
      sign_q    <= 1'b0;
      avg_q     <= '0;
      stopped_q <= 1'b1;
      rate_q    <= '0;
      valid_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (init_i) begin
        win_q     <= win_clamped;
        max_q     <= max_period_i;
        dpc_q     <= dist_per_cnt_i;
        avg_q     <= '0;
        stopped_q <= 1'b1;
        rate_q    <= '0;
      end else if (timeout) begin
        stopped_q <= 1'b1;
        rate_q    <= '0;
      end else if (push && full_next) begin
        avg_q <= avg_next;
        if (over_max) begin
          stopped_q <= 1'b1;
          rate_q    <= '0;
        end else begin
          stopped_q <= 1'b0;
          sign_q    <= dir_i;
        end
      end else if (div_done) begin
        rate_q  <= sign_q ? $signed({1'b0, quo}) : -$signed({1'b0, quo});
        valid_q <= 1'b1;
      end
    end
  end

  assign avg_period_o = avg_q;
  assign stopped_o    = stopped_q;
  assign rate_o       = rate_q;
  assign rate_valid_o = valid_q;
endmodule

// File: rtl/enc_rate_unit_chk.sv
`timescale 1ns/1ps
module enc_rate_unit_chk #(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned DPC_W = 24
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  init_i,
  input logic                  tick_i,
  input logic [CNT_W-1:0]      avg_period_o,
  input logic                  stopped_o,
  input logic signed [DPC_W:0] rate_o,
  input logic                  rate_valid_o,
  input logic [CNT_W-1:0]      max_q
);
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_valid_o |=> !rate_valid_o); // R7

  AST_VALID_WHILE_RUNNING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_valid_o |-> !stopped_o); // R7

  AST_STOPPED_ZERO_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stopped_o |-> (rate_o == '0)); // R5

  AST_AVG_WITHIN_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stopped_o |-> (avg_period_o <= max_q)); // R5

  AST_AVG_MOVES_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(avg_period_o) |-> ($past(tick_i) || $past(init_i))); // R3

  AST_INIT_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (stopped_o && avg_period_o == '0)); // R9
endmodule

bind enc_rate_unit enc_rate_unit_chk #(.CNT_W(CNT_W), .DPC_W(DPC_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .init_i       (init_i),
  .tick_i       (tick_i),
  .avg_period_o (avg_period_o),
  .stopped_o    (stopped_o),
  .rate_o       (rate_o),
  .rate_valid_o (rate_valid_o),
  .max_q        (max_q)
);

// File: tb/enc_rate_unit_bench.sv
`timescale 1ns/1ps
module enc_rate_unit_bench;
  localparam int CW = 16;
  localparam int DW = 16;
  localparam int WL = 4;

  typedef struct packed {
    int k; int mp; int dd; int per; int d; int avg; int rt;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{0, 100, 1000,  7, 1,  7,   142},
    '{2, 100, 50000, 13, 0, 13, -3846},
    '{4, 200, 65535, 3, 1,  3, 21845},
    '{1, 60,  9,     40, 1, 40,    0},
    '{3, 500, 1234,  5, 0,  5,  -246},
    '{7, 100, 6000,  10, 1, 10,   600}
  };

  logic clk = 1'b0, rst_n = 1'b0, init = 1'b0, tick = 1'b0, dir = 1'b0;
  logic [2:0] k = '0;
  logic [CW-1:0] maxp = '0;
  logic [DW-1:0] dpc = '0;
  logic [CW-1:0] avg;
  logic stopped;
  logic signed [DW:0] rate;
  logic rv;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  enc_rate_unit #(.CNT_W(CW), .DPC_W(DW), .WIN_LOG2_MAX(WL)) u_enc_rate_unit (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init), .win_log2_i(k),
    .max_period_i(maxp), .dist_per_cnt_i(dpc), .tick_i(tick), .dir_i(dir),
    .avg_period_o(avg), .stopped_o(stopped), .rate_o(rate), .rate_valid_o(rv)
  );

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_init(int kk, int mp, int dd);
    k = 3'(kk); maxp = CW'(mp); dpc = DW'(dd);
    init = 1'b1;
    @(negedge clk);
    init = 1'b0;
  endtask

  task automatic pulse(logic d);
    tick = 1'b1; dir = d;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic gap_pulse(int p, logic d);
    idle(p - 1);
    pulse(d);
  endtask

  task automatic wait_rate(int n, output int pulses, output int lat, output longint val);
    pulses = 0; lat = -1; val = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (rv) begin
        pulses++;
        if (lat < 0) lat = i;
        val = rate;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int np, lat;
    longint v;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 stopped", stopped, 1);
    chk("R1 avg", avg, 0);
    chk("R1 rate", rate, 0);
    chk("R1 valid", rv, 0);

    // table: constant period, window filled, rate checked (R2 R3 R7 R8)
    for (int t = 0; t < 6; t++) begin
      int n;
      do_init(VECS[t].k, VECS[t].mp, VECS[t].dd);
      n = 1 << ((VECS[t].k > 4) ? 4 : VECS[t].k);
      pulse(1'(VECS[t].d));
      for (int j = 0; j < n; j++) gap_pulse(VECS[t].per, 1'(VECS[t].d));
      chk("R3 avg", avg, VECS[t].avg);
      chk("R2 stopped clear", stopped, 0);
      wait_rate(24, np, lat, v);
      chk("R7 one pulse", np, 1);
      chk("R7 latency", lat, DW + 1);
      chk(VECS[t].d ? "R7 rate" : "R8 negative rate", v, VECS[t].rt);
    end

    // R3 sliding window of four with mixed periods, R4 fill
    do_init(2, 100, 1000);
    pulse(1);
    gap_pulse(10, 1); gap_pulse(20, 1); gap_pulse(30, 1);
    chk("R4 not full stopped", stopped, 1);
    chk("R4 not full avg", avg, 0);
    chk("R4 not full rate", rate, 0);
    gap_pulse(41, 1);
    chk("R3 mixed avg", avg, 25);
    chk("R4 full stopped", stopped, 0);
    gap_pulse(50, 1);
    chk("R3 slide avg", avg, 35);

    // R6 timeout without tick, exact edge
    do_init(0, 30, 100);
    pulse(1);
    gap_pulse(10, 1);
    chk("R2 window1 avg", avg, 10);
    idle(30);
    chk("R6 before limit", stopped, 0);
    chk("R7 rate before stop", rate, 10);
    idle(1);
    chk("R6 stopped", stopped, 1);
    chk("R5 rate zero", rate, 0);
    // R4 after a stop the first tick only arms
    pulse(0);
    chk("R4 rearm stopped", stopped, 1);
    gap_pulse(10, 0);
    chk("R4 resume", stopped, 0);
    chk("R4 resume avg", avg, 10);
    wait_rate(24, np, lat, v);
    chk("R8 reverse", v, -10);

    // R9 config ignored without init
    do_init(0, 100, 1000);
    k = 3'd2; maxp = CW'(5); dpc = DW'(7);
    pulse(1);
    gap_pulse(7, 1);
    chk("R9 avg", avg, 7);
    chk("R9 stopped", stopped, 0);
    wait_rate(24, np, lat, v);
    chk("R9 rate", v, 142);

    // R10 restart during division
    do_init(0, 100, 800);
    pulse(1);
    gap_pulse(4, 1);
    gap_pulse(8, 1);
    wait_rate(24, np, lat, v);
    chk("R10 pulses", np, 1);
    chk("R10 rate", v, 100);
    chk("R10 latency", lat, DW + 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule